// File: doc/BRIEF.md
# Panel Raster Timing Generator

This block produces the line and frame timing for a small display panel that takes pixel bytes on a parallel bus. It runs from one pixel clock and keeps two counters. A pixel counter walks across each line. A line counter walks down the frame and moves only when a line ends. From these counts it drives a horizontal sync, a vertical sync, a data-valid window and a one-cycle frame-start pulse. The clock sent to the panel is the pixel clock inverted, so the panel samples sync and data half a cycle after they change.

The data byte carries a test pattern. Inside the horizontal active window a three-step phase cycles 0, 1, 2 on every pixel. Outside the window it rests at 3. A 2-bit select input picks one phase, and that phase emits full intensity (0x7F). Every other phase emits zero, so one colour component of a three-component pixel stream lights up. The default geometry is 1171 pixel clocks per line and 262 lines per frame. Every dimension is a parameter.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_n is low (synchronous, active low), hsync, vsync, de and frame_start are 0 and pix_data is 0x00.
- R2: A line lasts H_TOTAL (default 1171) pixel clocks. hsync is 0 for the first H_SYNC (default 1) clock of each line and 1 for the rest.
- R3: The line number advances only on the last pixel of a line. A frame holds V_TOTAL (default 262) lines. vsync is 0 for the whole of the first V_SYNC (default 1) lines and 1 for all other lines.
- R4: de is 1 exactly when the pixel position in the line is in [H_BACK, H_BACK+H_ACTIVE) (default 152..1111, 960 pixels) and the line number is in [V_BACK, V_BACK+V_ACTIVE) (default lines 14..253, 240 lines). The sync pulse counts as part of each back porch.
- R5: In the horizontal window, the pattern phase is (position - H_BACK) mod 3. With pat_sel in 0..2, pix_data is 0x7F when the phase equals pat_sel and 0x00 otherwise. Outside the horizontal window pix_data is 0x00. The vertical blanking lines do not gate this pattern.
- R6: With pat_sel = 3, pix_data is 0x00 on every cycle.
- R7: panel_clk is the logical inverse of clk at all times.
- R8: frame_start is 1 for exactly one clock, at the first pixel of line 0 of each frame, including the first frame after reset.
- R9: hsync, vsync, de, frame_start and the phase are registered and show raster position k after the (k+1)-th rising edge following reset release. pix_data follows pat_sel combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_sel | input | 2 | Selects the lit pattern phase (3 = dark) |
| panel_clk | output | 1 | Inverted pixel clock for the panel |
| hsync | output | 1 | Line sync, active low |
| vsync | output | 1 | Frame sync, active low |
| de | output | 1 | Data-valid window |
| pix_data | output | 8 | Test-pattern data byte |
| frame_start | output | 1 | One-cycle pulse at the first pixel of a frame |

## Verification
Every registered output shows raster position k one rising edge after the counter holds k. The bench's reference model therefore advances its position index on each rising edge and compares all outputs at the next falling edge. The pattern byte depends on pat_sel without a register. The bench changes pat_sel at a falling edge just after a comparison, and the next comparison uses the new select value. The bench runs with a reduced geometry so that several whole frames fit in the run. A mid-frame reset also checks that the first position after release is the start of a frame.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int H_TOTAL  = 1171,
  parameter int H_SYNC   = 1,
  parameter int H_BACK   = 152,
  parameter int H_ACTIVE = 960,
  parameter int V_TOTAL  = 262,
  parameter int V_SYNC   = 1,
  parameter int V_BACK   = 14,
  parameter int V_ACTIVE = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pat_sel,
  output logic       panel_clk,
  output logic       hsync,
  output logic       vsync,
  output logic       de,
  output logic [7:0] pix_data,
  output logic       frame_start
);
  localparam int HW = $clog2(H_TOTAL + 1);
  localparam int VW = $clog2(V_TOTAL + 1);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_SYNC_END = HW'(H_SYNC);
  localparam logic [VW-1:0] V_SYNC_END = VW'(V_SYNC);
  localparam logic [HW-1:0] H_ACT_LO = HW'(H_BACK);
  localparam logic [HW-1:0] H_ACT_HI = HW'(H_BACK + H_ACTIVE);
  localparam logic [VW-1:0] V_ACT_LO = VW'(V_BACK);
  localparam logic [VW-1:0] V_ACT_HI = VW'(V_BACK + V_ACTIVE);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [1:0]    phase;

  wire h_last = (hcnt == H_LAST);
  wire v_last = (vcnt == V_LAST);
  wire h_act  = (hcnt >= H_ACT_LO) && (hcnt < H_ACT_HI);
  wire v_act  = (vcnt >= V_ACT_LO) && (vcnt < V_ACT_HI);

  assign panel_clk = ~clk;
  assign pix_data  = (pat_sel != 2'd3 && phase == pat_sel) ? 8'h7F : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt        <= '0;
      vcnt        <= '0;
      phase       <= 2'd3;
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      de          <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      hcnt <= h_last ? '0 : hcnt + HW'(1);
      if (h_last)
        vcnt <= v_last ? '0 : vcnt + VW'(1);
      hsync       <= (hcnt >= H_SYNC_END);
      vsync       <= (vcnt >= V_SYNC_END);
      de          <= h_act && v_act;
      frame_start <= (hcnt == '0) && (vcnt == '0);
      if (h_act)
        phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
      else
        phase <= 2'd3;
    end
  end
endmodule

module raster_timing_gen_chk #(
  parameter int HW = 11,
  parameter int H_LAST = 1170
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pat_sel,
  input logic          panel_clk,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [7:0]    pix_data,
  input logic          frame_start,
  input logic [HW-1:0] hcnt
);
  a_r2_hsync_single: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |=> hsync);
  a_r3_wrap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == HW'(H_LAST)) |=> (hcnt == '0));
  a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hsync && vsync));
  a_r5_byte_values: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_data == 8'h00) || (pix_data == 8'h7F));
  a_r6_dark_select: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == 2'd3) |-> (pix_data == 8'h00));
  a_r8_frame_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!hsync && !vsync));
  a_r8_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!hsync && !vsync && !de && !frame_start));
  always @(negedge clk) a_r7_inverted: assert (panel_clk == 1'b1);
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.HW(HW), .H_LAST(H_TOTAL - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .panel_clk(panel_clk),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_data(pix_data),
  .frame_start(frame_start), .hcnt(hcnt));

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  localparam int HT = 20, HS = 1, HB = 4, HA = 10;
  localparam int VT = 8,  VS = 1, VB = 2, VA = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pat_sel = 2'd0;
  logic panel_clk, hsync, vsync, de, frame_start;
  logic [7:0] pix_data;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  raster_timing_gen #(.H_TOTAL(HT), .H_SYNC(HS), .H_BACK(HB), .H_ACTIVE(HA),
                      .V_TOTAL(VT), .V_SYNC(VS), .V_BACK(VB), .V_ACTIVE(VA))
    u_raster_timing_gen (.clk(clk), .rst_n(rst_n), .pat_sel(pat_sel),
      .panel_clk(panel_clk), .hsync(hsync), .vsync(vsync), .de(de),
      .pix_data(pix_data), .frame_start(frame_start));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_reset();
    chk("R1 hsync", hsync, 0);
    chk("R1 vsync", vsync, 0);
    chk("R1 de", de, 0);
    chk("R1 frame_start", frame_start, 0);
    chk("R1 pix_data", pix_data, 0);
  endtask

  task automatic check_pos(input int p);
    int h, v, ph, exp_d;
    h = p % HT;
    v = (p / HT) % VT;
    ph = (h >= HB && h < HB + HA) ? (h - HB) % 3 : 3;
    exp_d = (pat_sel != 2'd3 && ph == int'(pat_sel)) ? 8'h7F : 8'h00;
    chk("R2 hsync", hsync, (h >= HS) ? 1 : 0);
    chk("R3 vsync", vsync, (v >= VS) ? 1 : 0);
    chk("R4 de", de, (h >= HB && h < HB + HA && v >= VB && v < VB + VA) ? 1 : 0);
    if (pat_sel == 2'd3) chk("R6 pix_data", pix_data, 0);
    else chk("R5 pix_data", pix_data, exp_d);
    chk("R8 frame_start", frame_start, (h == 0 && v == 0) ? 1 : 0);
    chk("R7 panel_clk", panel_clk, 1);
  endtask

  task automatic run(input int n);
    for (int p = 0; p < n; p++) begin
      @(posedge clk);
      @(negedge clk);
      check_pos(p);
      pat_sel = 2'(((p + 1) / HT) % 4);
      if (p == 0) chk("R9 first position is frame start", frame_start, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    run(HT * VT * 2 + 57);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset();
    pat_sel = 2'd0;
    rst_n = 1'b1;
    run(HT * VT * 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule